// File: doc/BRIEF.md
# Manchester Receive Decoder with Polarity Control

This block turns a single-bit, already-sliced 10BASE-T receive line into nibble-wide receive data. The line is oversampled at eight times the bit rate. The block finds the transition in the middle of each bit and uses it to recover bit timing. It corrects a reversed wire pair, decodes each Manchester symbol into one bit, and packs the bits into 4-bit nibbles. The nibbles leave on a receive port in media-independent-interface style, with data, a valid flag and a one-cycle clock-enable strobe.

Polarity has two modes, chosen by `pol_manual`. In automatic mode, which is what the block runs in when `pol_manual` is low (its reset value), the block inspects the start-of-frame delimiter. If the delimiter arrives with every bit complemented, the block inverts the stream for the rest of that frame. In manual mode, the `man_rev` input forces the inversion directly. In both modes `pol_inv` reports the inversion currently in force.

Top module: `mrx_decoder`

## Requirements
- R1: The line is sampled once per clock, with OSR = 8 samples per bit. A line transition is taken as a mid-bit edge only if at least 3/4 of a bit (6 samples) has passed since the previous accepted edge, or if no edge has been accepted for 2 bit times. Transitions on bit boundaries are therefore ignored.
- R2: Each decoded bit is the complement of the line sample taken a quarter bit (2 samples) before the accepted mid-bit edge. With normal polarity, a low-to-high mid-bit edge therefore decodes as 1 and a high-to-low edge as 0.
- R3: After reset, the block is in automatic polarity mode. At that point `rx_dv`, `rx_ce`, `rxd` and `pol_inv` are all 0.
- R4: In automatic mode, the delimiter arriving as the bit sequence 1,0,1,0,1,0,1,1 starts a frame with no inversion and `pol_inv` = 0. The complemented sequence 0,1,0,1,0,1,0,0 starts a frame with inversion and `pol_inv` = 1.
- R5: In automatic mode, the inversion and `pol_inv` keep their value after the frame ends. They change only when the next delimiter is recognised.
- R6: When `pol_manual` = 1, `pol_inv` equals `man_rev` one clock later, and decoding inverts the stream when `man_rev` = 1. Only a delimiter seen in the forced polarity starts a frame, so a frame of the opposite polarity produces no `rx_ce`.
- R7: The first decoded bit after the delimiter becomes nibble bit 0 (LSB first). Each completed nibble is placed on `rxd` together with a one-cycle `rx_ce` pulse. `rx_dv` rises with the first nibble of a frame.
- R8: When no edge has been accepted for 2 bit times (16 samples), the frame ends, any partial nibble is discarded, and `rx_dv` falls within one nibble time of the line going quiet.
- R9: `rx_ce` is never high while `rx_dv` is low, and it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 8 ticks per bit |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Sliced receive line sample |
| pol_manual | input | 1 | 1 selects manual polarity, 0 selects automatic |
| man_rev | input | 1 | Forced inversion in manual mode |
| rxd | output | 4 | Received nibble, LSB is the earliest bit |
| rx_ce | output | 1 | One-cycle strobe marking a new nibble on `rxd` |
| rx_dv | output | 1 | Receive data valid for the current frame |
| pol_inv | output | 1 | Inversion currently applied |

## Verification
Two events can coincide. When the delimiter is recognised, the polarity decision is updated, and the very next strobe decodes the first data bit using that decision. The bench sends frames with both line polarities in automatic and manual modes, then compares the first nibble against the data it sent. A second coincidence occurs when carrier loss meets a half-filled nibble register. Frames whose bit count is not a multiple of four must yield exactly the whole nibbles, with `rx_dv` falling within the allowed window.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam int SFD_W = 8;
  // delimiter in arrival order, oldest bit at the MSB
  localparam logic [SFD_W-1:0] SFD_PAT = 8'hAB;

  typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;
endpackage

// File: rtl/mrx_bit_recover.sv
module mrx_bit_recover #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic bit_stb,
  output logic bit_raw,
  output logic carrier_lost
);
  localparam int QB   = OSR / 4;
  localparam int WIN  = (3 * OSR) / 4;
  localparam int LOSS = 2 * OSR;
  localparam int CW   = $clog2(LOSS + 1);

  logic [QB:0]   hist;
  logic [CW-1:0] gap;
  logic          edge_seen;
  logic          take;

  assign edge_seen = hist[0] ^ hist[1];
  // gap saturates at LOSS >= WIN, so an idle receiver takes any edge
  assign take      = edge_seen && (gap >= CW'(WIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist         <= '0;
      gap          <= CW'(LOSS);
      bit_stb      <= 1'b0;
      bit_raw      <= 1'b0;
      carrier_lost <= 1'b0;
    end else begin
      hist         <= {hist[QB-1:0], rx_in};
      bit_stb      <= take;
      carrier_lost <= !take && (gap == CW'(LOSS - 1));
      if (take) begin
        bit_raw <= ~hist[QB];
        gap     <= CW'(1);
      end else if (gap != CW'(LOSS)) begin
        gap <= gap + CW'(1);
      end
    end
  end

  // R1: two accepted edges never sit on adjacent samples
  a_r1_edge_spacing: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

endmodule

// File: rtl/mrx_polarity.sv
module mrx_polarity
  import mrx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic bit_raw,
  input  logic carrier_lost,
  input  logic pol_manual,
  input  logic man_rev,
  output logic data_stb,
  output logic data_bit,
  output logic inv_q
);
  rx_state_e        st;
  logic [SFD_W-1:0] win;
  logic [SFD_W-1:0] win_nxt;
  logic             hit_norm;
  logic             hit_inv;
  logic             sfd_ok;

  always_comb begin
    win_nxt  = {win[SFD_W-2:0], bit_raw};
    hit_norm = (win_nxt == SFD_PAT);
    hit_inv  = (win_nxt == ~SFD_PAT);
    sfd_ok   = (st == ST_HUNT) && bit_stb &&
               (pol_manual ? (man_rev ? hit_inv : hit_norm) : (hit_norm || hit_inv));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HUNT;
      win      <= '0;
      data_stb <= 1'b0;
      data_bit <= 1'b0;
      inv_q    <= 1'b0;
    end else begin
      data_stb <= 1'b0;
      if (carrier_lost) begin
        st  <= ST_HUNT;
        win <= '0;
      end else if (st == ST_HUNT) begin
        if (bit_stb) win <= win_nxt;
        if (sfd_ok) begin
          st <= ST_FRAME;
          if (!pol_manual) inv_q <= hit_inv;
        end
      end else begin
        data_stb <= bit_stb;
        if (bit_stb) data_bit <= bit_raw ^ inv_q;
      end
      if (pol_manual) inv_q <= man_rev;
    end
  end

  // R6: manual mode drives the status from the control input
  a_r6_manual_follow: assert property (@(posedge clk) disable iff (rst)
    ($past(pol_manual) && !$past(rst)) |-> (inv_q == $past(man_rev)));

  // R5: automatic mode changes inversion only on a recognised delimiter
  a_r5_auto_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pol_manual) && !$stable(inv_q)) |-> $past(sfd_ok));

endmodule

// File: rtl/mrx_nibble_pack.sv
module mrx_nibble_pack #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_stb,
  input  logic          data_bit,
  input  logic          carrier_lost,
  output logic [NW-1:0] rxd,
  output logic          rx_ce,
  output logic          rx_dv
);
  localparam int CW = $clog2(NW);

  logic [NW-1:0] sh;
  logic [NW-1:0] sh_nxt;
  logic [CW-1:0] cnt;

  // earliest bit shifts down to bit 0
  assign sh_nxt = {data_bit, sh[NW-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      cnt   <= '0;
      rxd   <= '0;
      rx_ce <= 1'b0;
      rx_dv <= 1'b0;
    end else begin
      rx_ce <= 1'b0;
      if (carrier_lost) begin
        sh    <= '0;
        cnt   <= '0;
        rx_dv <= 1'b0;
      end else if (data_stb) begin
        sh <= sh_nxt;
        if (cnt == CW'(NW - 1)) begin
          cnt   <= '0;
          rxd   <= sh_nxt;
          rx_ce <= 1'b1;
          rx_dv <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R9: strobe only inside a valid frame, never back to back
  a_r9_ce_in_dv: assert property (@(posedge clk) disable iff (rst)
    rx_ce |-> rx_dv);
  a_r9_ce_single: assert property (@(posedge clk) disable iff (rst)
    rx_ce |=> !rx_ce);
  // R8: valid drops only after a carrier-loss event
  a_r8_dv_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_dv) |-> $past(carrier_lost));

endmodule

// File: rtl/mrx_decoder.sv
module mrx_decoder #(
  parameter int OSR = 8,
  parameter int NW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_in,
  input  logic          pol_manual,
  input  logic          man_rev,
  output logic [NW-1:0] rxd,
  output logic          rx_ce,
  output logic          rx_dv,
  output logic          pol_inv
);
  logic bit_stb, bit_raw, carrier_lost;
  logic data_stb, data_bit;

  mrx_bit_recover #(.OSR(OSR)) u_rec (
    .clk(clk), .rst(rst), .rx_in(rx_in),
    .bit_stb(bit_stb), .bit_raw(bit_raw), .carrier_lost(carrier_lost)
  );

  mrx_polarity u_pol (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_raw(bit_raw),
    .carrier_lost(carrier_lost), .pol_manual(pol_manual), .man_rev(man_rev),
    .data_stb(data_stb), .data_bit(data_bit), .inv_q(pol_inv)
  );

  mrx_nibble_pack #(.NW(NW)) u_pack (
    .clk(clk), .rst(rst), .data_stb(data_stb), .data_bit(data_bit),
    .carrier_lost(carrier_lost), .rxd(rxd), .rx_ce(rx_ce), .rx_dv(rx_dv)
  );

  // R3: nothing is presented while no frame is valid after reset
  a_r3_quiet_start: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rx_ce && !rx_dv));

endmodule

// File: tb/mrx_decoder_tb.sv
module mrx_decoder_tb;
  localparam int OSR = 8;
  localparam int NW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b0;
  logic pol_manual = 1'b0;
  logic man_rev = 1'b0;
  logic [NW-1:0] rxd;
  logic rx_ce, rx_dv, pol_inv;

  int checks = 0;
  int errors = 0;
  int nib_total = 0;
  logic [NW-1:0] nib_q [0:63];

  always #2.5 clk = ~clk;

  mrx_decoder #(.OSR(OSR), .NW(NW)) u_dut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .pol_manual(pol_manual),
    .man_rev(man_rev), .rxd(rxd), .rx_ce(rx_ce), .rx_dv(rx_dv), .pol_inv(pol_inv)
  );

  always @(negedge clk) begin
    if (rx_ce) begin
      nib_q[nib_total % 64] = rxd;
      nib_total = nib_total + 1;
    end
  end

  // fields: [31] line inverted, [30] manual, [29] man_rev, [28] expected status,
  // [27:24] expected nibbles, [20:16] data bits sent, [15:0] data (LSB sent first)
  localparam logic [31:0] VEC [0:7] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 3'd0, 5'd16, 16'h3C5A},
    {1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 3'd0, 5'd16, 16'h9E71},
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd4, 3'd0, 5'd16, 16'hBEEF},
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 3'd0, 5'd16, 16'h1234},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 3'd0, 5'd16, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 3'd0, 5'd10, 16'h02D6},
    {1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 3'd0, 5'd16, 16'hF00F},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 3'd0, 5'd16, 16'h0FF0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic inv);
    rx_in = ~b ^ inv;
    hold(OSR / 2);
    rx_in = b ^ inv;
    hold(OSR / 2);
  endtask

  task automatic run_frame(input logic [31:0] v, input int idx);
    logic inv;
    int start, ecnt, nb;
    inv  = v[31];
    ecnt = int'(v[27:24]);
    nb   = int'(v[20:16]);
    pol_manual = v[30];
    man_rev    = v[29];
    rx_in = inv;                 // first half level of the first preamble bit
    hold(4 * OSR);
    start = nib_total;
    for (int i = 0; i < 12; i++) send_bit(i % 2 == 0, inv);
    for (int i = 0; i < 8; i++) send_bit(i == 7 ? 1'b1 : (i % 2 == 0), inv);
    for (int i = 0; i < nb; i++) send_bit(v[i], inv);
    hold(1);
    chk(rx_dv == (ecnt > 0), "R7 dv during frame", int'(rx_dv), int'(ecnt > 0));
    hold(6 * OSR);
    chk(rx_dv == 1'b0, "R8 dv dropped after idle", int'(rx_dv), 0);
    chk(nib_total - start == ecnt, "R6/R8 nibble count", nib_total - start, ecnt);
    for (int k = 0; k < ecnt && k < nib_total - start; k++)
      chk(nib_q[(start + k) % 64] == v[4*k +: 4], "R7 nibble value (R2 decode)",
          int'(nib_q[(start + k) % 64]), int'(v[4*k +: 4]));
    chk(pol_inv == v[28], $sformatf("R4/R5 status held after vector %0d", idx),
        int'(pol_inv), int'(v[28]));
  endtask

  initial begin
    hold(150000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hold(4);
    rst = 1'b0;
    hold(1);
    // R3 reset state
    chk(rx_dv == 1'b0, "R3 rx_dv", int'(rx_dv), 0);
    chk(rx_ce == 1'b0, "R3 rx_ce", int'(rx_ce), 0);
    chk(rxd == '0, "R3 rxd", int'(rxd), 0);
    chk(pol_inv == 1'b0, "R3 pol_inv", int'(pol_inv), 0);

    // R1 R2 R4 R5 R6 R7 R8 via vector table
    for (int i = 0; i < 8; i++) run_frame(VEC[i], i);

    // R6 manual status follows the control input
    pol_manual = 1'b1; man_rev = 1'b1;
    hold(2);
    chk(pol_inv == 1'b1, "R6 manual set", int'(pol_inv), 1);
    man_rev = 1'b0;
    hold(2);
    chk(pol_inv == 1'b0, "R6 manual clear", int'(pol_inv), 0);
    man_rev = 1'b1;
    hold(2);
    pol_manual = 1'b0; man_rev = 1'b0;
    hold(OSR * 4);
    // R5 automatic mode keeps the last inversion with no delimiter seen
    chk(pol_inv == 1'b1, "R5 auto hold after mode switch", int'(pol_inv), 1);

    // R1 boundary edges: long run of equal bits must decode exactly
    run_frame({1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 3'd0, 5'd16, 16'hFF00}, 8);

    // R3 reset mid-stream clears outputs
    rst = 1'b1;
    hold(2);
    rst = 1'b0;
    hold(1);
    chk(rx_dv == 1'b0 && pol_inv == 1'b0, "R3 reset again", int'({rx_dv, pol_inv}), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule